// File: doc/BRIEF.md
# Drift-Cell Segment Pattern Finder

This block watches a group of eight neighbouring drift cells for a short, stiff track segment. One of the cells is the pivot. Every cell has a small timer. A binary hit on the cell starts the timer, and the timer then counts clock ticks. Together the eight timer values form a lookup address. A loadable weight table maps that address to a 2-bit quality weight.

A hit on the pivot opens a selection window three ticks long. During the window the block keeps the highest-weight pattern it sees. When the window closes it reports that pattern's weight, the tick inside the window at which it occurred, and the table address that produced it. Later stages use these values to refine segment time and position.

Table contents are written through a simple synchronous port while the search is switched off.

Top module: `seg_pattern_finder`

## Requirements
- R1: After reset, segValid is 0, and segWeight, segOffset and segAddr are all 0.
- R2: Cell i's timer occupies lookup-address bits [2i+1:2i], and a value of 0 means idle. A hit sampled on an idle cell loads 1 at that edge. A running timer advances by one at each later edge. While a window is open, a timer holds at 3.
- R3: While no window is open, a timer that reads 3 returns to 0 at the next edge. An isolated hit therefore lasts three ticks.
- R4: With the search enabled and no window open, a hit sampled on the pivot (cell 4) opens a window. The window covers the three ticks in which the pivot timer reads 1, 2 and 3. A hit on a cell whose timer is running is ignored.
- R5: The table entry selected by the current address gives the weight: 0 no segment, 1 low-quality, 2 three-layer, 3 four-layer. Across the window the highest weight wins, and on a tie the earlier tick wins. segOffset is the winning tick (0, 1 or 2), which equals the pivot timer minus 1.
- R6: If the pivot hit is sampled at edge k, segValid is high for exactly one cycle, after edge k+3. segWeight, segOffset and segAddr keep the reported values until the next report.
- R7: A window whose best weight is 0 gives no report, and the outputs keep their previous values.
- R8: When a window closes, every timer clears. Hits sampled at the closing edge are discarded, including a pivot hit.
- R9: While searchEn is low, all timers are cleared and hits are ignored. An open window is abandoned with no report.
- R10: At a rising edge with tblWe high and searchEn low, entry tblAddr takes tblData. A write request while searchEn is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| searchEn | input | 1 | Enables segment search; low allows table writes |
| hitIn | input | 8 | Per-cell hit bits, cell 4 is the pivot |
| tblWe | input | 1 | Table write request |
| tblAddr | input | 16 | Table entry to write |
| tblData | input | 2 | Weight to write |
| segValid | output | 1 | One-cycle strobe for a found segment |
| segWeight | output | 2 | Weight of the reported segment |
| segOffset | output | 2 | Window tick of the reported segment |
| segAddr | output | 16 | Timer pattern of the reported segment |

## Verification
A timer that is stuck, fails to saturate or fails to expire changes the lookup address. Such a fault appears as a wrong segAddr and usually a wrong segWeight at the very next report, four cycles after the pivot hit. A fault in the window tick counter appears as a wrong segOffset, or as a strobe one cycle early or late. Leftover timer state after a window close, or after the search is disabled, shows up in the address of the next report.

// File: rtl/segfind_pkg.sv
package segfind_pkg;

  // Number of ticks a pivot hit keeps the selection window open.
  localparam int WIN_TICKS = 3;
  localparam int OFF_W     = $clog2(WIN_TICKS);
  localparam int WGT_W     = 2;

  // Strobes from control to the datapath.
  typedef struct packed {
    logic             active;  // a selection window is open
    logic             first;   // first tick of the window
    logic             finish;  // last tick, report at the coming edge
    logic             clear;   // wipe every timer at the coming edge
    logic [OFF_W-1:0] tick;    // tick index inside the window
  } ctrlStrobe_t;

endpackage

// File: rtl/segfind_table.sv
module segfind_table #(
  parameter int ADDR_W   = 16,
  parameter int WGT_W    = 2,
  parameter int PER_WORD = 64
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WGT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WGT_W-1:0]  rdWeight
);

  // Weights are packed many to a word, to keep the row count small.
  localparam int SEL_W  = $clog2(PER_WORD);
  localparam int ROW_W  = ADDR_W - SEL_W;
  localparam int DEPTH  = 2 ** ROW_W;
  localparam int WORD_W = PER_WORD * WGT_W;
  localparam int SH     = $clog2(WGT_W);
  localparam int LSB_W  = SEL_W + SH;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [LSB_W-1:0]  wrLsb;
  logic [LSB_W-1:0]  rdLsb;
  logic [WORD_W-1:0] rdWord;

  assign wrLsb = {wrAddr[SEL_W-1:0], {SH{1'b0}}};
  assign rdLsb = {rdAddr[SEL_W-1:0], {SH{1'b0}}};

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr[ADDR_W-1:SEL_W]][wrLsb +: WGT_W] <= wrData;
  end

  assign rdWord   = mem[rdAddr[ADDR_W-1:SEL_W]];
  assign rdWeight = rdWord[rdLsb +: WGT_W];

endmodule

// File: rtl/segfind_ctrl.sv
module segfind_ctrl
  import segfind_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        searchEn,
  input  logic        pivotHit,
  output ctrlStrobe_t strobe
);

  logic             active;
  logic [OFF_W-1:0] tick;
  logic             lastTick;

  assign lastTick = active && (tick == OFF_W'(WIN_TICKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      tick   <= '0;
    end else if (!searchEn) begin
      active <= 1'b0;
      tick   <= '0;
    end else if (!active) begin
      active <= pivotHit;
      tick   <= '0;
    end else if (lastTick) begin
      active <= 1'b0;
      tick   <= '0;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  always_comb begin
    strobe.active = active;
    strobe.first  = active && (tick == '0);
    strobe.finish = searchEn && lastTick;
    strobe.clear  = !searchEn || lastTick;
    strobe.tick   = tick;
  end

  AST_WINDOW_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    lastTick |=> !active); // R8

  AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    (active && !lastTick && searchEn) |=> (active && tick == $past(tick) + 1'b1)); // R4

  AST_DISABLE_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    !searchEn |=> !active); // R9

endmodule

// File: rtl/segfind_datapath.sv
module segfind_datapath
  import segfind_pkg::*;
#(
  parameter int NUM_CELLS = 8,
  parameter int CTR_W     = 2,
  parameter int PIVOT_IDX = 4,
  localparam int ADDR_W   = NUM_CELLS * CTR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CELLS-1:0] hitIn,
  input  ctrlStrobe_t       strobe,
  output logic [ADDR_W-1:0] lookupAddr,
  input  logic [WGT_W-1:0]  lookupWeight,
  output logic              segValid,
  output logic [WGT_W-1:0]  segWeight,
  output logic [OFF_W-1:0]  segOffset,
  output logic [ADDR_W-1:0] segAddr
);

  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};

  logic [CTR_W-1:0] cnt [NUM_CELLS];

  // Per-cell drift timers.
  for (genvar g = 0; g < NUM_CELLS; g++) begin : gCell
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt[g] <= '0;
      end else if (strobe.clear) begin
        cnt[g] <= '0;
      end else if (cnt[g] == '0) begin
        if (hitIn[g]) cnt[g] <= CTR_W'(1);
      end else if (cnt[g] == CTR_MAX) begin
        if (!strobe.active) cnt[g] <= '0;
      end else begin
        cnt[g] <= cnt[g] + 1'b1;
      end
    end

    assign lookupAddr[g*CTR_W +: CTR_W] = cnt[g];

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
      ($past(cnt[g]) != '0 && $past(cnt[g]) != CTR_MAX && !$past(strobe.clear))
        |-> (cnt[g] == $past(cnt[g]) + 1'b1)); // R2
  end

  // Best-pattern tracking across the window.
  logic [WGT_W-1:0]  curWeight;
  logic              take;
  logic [WGT_W-1:0]  bestW;
  logic [OFF_W-1:0]  bestOff;
  logic [ADDR_W-1:0] bestAddr;
  logic [WGT_W-1:0]  finW;
  logic [OFF_W-1:0]  finOff;
  logic [ADDR_W-1:0] finAddr;
  logic              report;

  assign curWeight = (lookupAddr == '0) ? '0 : lookupWeight;
  assign take      = strobe.first || (curWeight > bestW);
  assign finW      = take ? curWeight   : bestW;
  assign finOff    = take ? strobe.tick : bestOff;
  assign finAddr   = take ? lookupAddr  : bestAddr;
  assign report    = strobe.finish && (finW != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestW    <= '0;
      bestOff  <= '0;
      bestAddr <= '0;
    end else if (strobe.active && take) begin
      bestW    <= curWeight;
      bestOff  <= strobe.tick;
      bestAddr <= lookupAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segValid  <= 1'b0;
      segWeight <= '0;
      segOffset <= '0;
      segAddr   <= '0;
    end else begin
      segValid <= report;
      if (report) begin
        segWeight <= finW;
        segOffset <= finOff;
        segAddr   <= finAddr;
      end
    end
  end

  AST_FIRST_PIVOT_ONE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.first |-> (cnt[PIVOT_IDX] == CTR_W'(1))); // R4

  AST_IDLE_PIVOT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.active |-> (cnt[PIVOT_IDX] == '0)); // R4

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (lookupAddr == '0)); // R8

  AST_VALID_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    segValid |-> (segWeight != '0)); // R7

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rstN)
    !segValid |-> ($stable(segAddr) && $stable(segWeight) && $stable(segOffset))); // R6

  AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    segValid |-> (segOffset < OFF_W'(WIN_TICKS))); // R5

endmodule

// File: rtl/seg_pattern_finder.sv
module seg_pattern_finder
  import segfind_pkg::*;
#(
  parameter int NUM_CELLS    = 8,
  parameter int CTR_W        = 2,
  parameter int PIVOT_IDX    = 4,
  parameter int TBL_PER_WORD = 64,
  localparam int ADDR_W      = NUM_CELLS * CTR_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 searchEn,
  input  logic [NUM_CELLS-1:0] hitIn,
  input  logic                 tblWe,
  input  logic [ADDR_W-1:0]    tblAddr,
  input  logic [WGT_W-1:0]     tblData,
  output logic                 segValid,
  output logic [WGT_W-1:0]     segWeight,
  output logic [OFF_W-1:0]     segOffset,
  output logic [ADDR_W-1:0]    segAddr
);

  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] lookupAddr;
  logic [WGT_W-1:0]  lookupWeight;
  logic              tblWrEn;

  assign tblWrEn = tblWe && !searchEn;

  segfind_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .searchEn (searchEn),
    .pivotHit (hitIn[PIVOT_IDX]),
    .strobe   (strobe)
  );

  segfind_datapath #(
    .NUM_CELLS (NUM_CELLS),
    .CTR_W     (CTR_W),
    .PIVOT_IDX (PIVOT_IDX)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .hitIn        (hitIn),
    .strobe       (strobe),
    .lookupAddr   (lookupAddr),
    .lookupWeight (lookupWeight),
    .segValid     (segValid),
    .segWeight    (segWeight),
    .segOffset    (segOffset),
    .segAddr      (segAddr)
  );

  segfind_table #(
    .ADDR_W   (ADDR_W),
    .WGT_W    (WGT_W),
    .PER_WORD (TBL_PER_WORD)
  ) u_tbl (
    .clk      (clk),
    .wrEn     (tblWrEn),
    .wrAddr   (tblAddr),
    .wrData   (tblData),
    .rdAddr   (lookupAddr),
    .rdWeight (lookupWeight)
  );

  AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    searchEn |-> !tblWrEn); // R10

endmodule

// File: tb/test_seg_pattern_finder.sv
module test_seg_pattern_finder;

  logic        clk = 1'b0;
  logic        rstN;
  logic        searchEn;
  logic [7:0]  hitIn;
  logic        tblWe;
  logic [15:0] tblAddr;
  logic [1:0]  tblData;
  logic        segValid;
  logic [1:0]  segWeight;
  logic [1:0]  segOffset;
  logic [15:0] segAddr;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  seg_pattern_finder i_seg_pattern_finder (
    .clk       (clk),
    .rstN      (rstN),
    .searchEn  (searchEn),
    .hitIn     (hitIn),
    .tblWe     (tblWe),
    .tblAddr   (tblAddr),
    .tblData   (tblData),
    .segValid  (segValid),
    .segWeight (segWeight),
    .segOffset (segOffset),
    .segAddr   (segAddr)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkOut(string req, logic v, logic [1:0] w, logic [1:0] o, logic [15:0] a);
    checks++;
    if ({segValid, segWeight, segOffset, segAddr} !== {v, w, o, a}) begin
      fails++;
      $display("FAIL %s: actual valid=%0b w=%0d off=%0d addr=%h, expected valid=%0b w=%0d off=%0d addr=%h",
               req, segValid, segWeight, segOffset, segAddr, v, w, o, a);
    end
  endtask

  task automatic checkValid(string req, logic v);
    checks++;
    if (segValid !== v) begin
      fails++;
      $display("FAIL %s: actual valid=%0b, expected valid=%0b", req, segValid, v);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [1:0] d);
    tblWe = 1'b1; tblAddr = a; tblData = d;
    tick();
    tblWe = 1'b0;
  endtask

  task automatic setW(logic [15:0] a0, logic [1:0] w0, logic [15:0] a1, logic [1:0] w1,
                      logic [15:0] a2, logic [1:0] w2);
    wr(a0, w0); wr(a1, w1); wr(a2, w2);
  endtask

  // Pivot hit alone, then three more edges up to the report.
  task automatic pivotRun();
    hitIn = 8'h10; tick();
    hitIn = 8'h00; tick(); tick(); tick();
  endtask

  task automatic testReset();
    checkOut("R1 reset", 1'b0, 2'd0, 2'd0, 16'h0000);
  endtask

  task automatic testBest();
    searchEn = 1'b0;
    setW(16'h0100, 2'd1, 16'h0200, 2'd3, 16'h0300, 2'd2);
    searchEn = 1'b1; tick();
    hitIn = 8'h10; tick();        // edge k
    hitIn = 8'h10; tick();        // R4: pivot running, hit ignored
    hitIn = 8'h00; tick();        // edge k+2
    checkValid("R6 not before k+3", 1'b0);
    tick();                       // edge k+3
    checkOut("R5 R4 best weight", 1'b1, 2'd3, 2'd1, 16'h0200);
    tick();
    checkOut("R6 one-cycle strobe, held outputs", 1'b0, 2'd3, 2'd1, 16'h0200);
  endtask

  task automatic testTie();
    searchEn = 1'b0;
    setW(16'h0100, 2'd2, 16'h0200, 2'd2, 16'h0300, 2'd1);
    searchEn = 1'b1;
    pivotRun();
    checkOut("R5 tie earlier wins", 1'b1, 2'd2, 2'd0, 16'h0100);
  endtask

  task automatic testNeighbour();
    searchEn = 1'b0;
    setW(16'h0102, 2'd1, 16'h4203, 2'd1, 16'h8303, 2'd3);
    searchEn = 1'b1;
    hitIn = 8'h01; tick();        // cell 0 starts
    hitIn = 8'h10; tick();        // pivot: 0x0102
    hitIn = 8'h80; tick();        // cell 7 starts: 0x4203
    hitIn = 8'h00; tick();        // 0x8303, cell 0 held at 3
    tick();
    checkOut("R2 timer encoding and saturation", 1'b1, 2'd3, 2'd2, 16'h8303);
  endtask

  task automatic testExpire();
    searchEn = 1'b0;
    setW(16'h0100, 2'd2, 16'h0200, 2'd0, 16'h0300, 2'd0);
    wr(16'h0103, 2'd3);
    searchEn = 1'b1;
    hitIn = 8'h01; tick();
    hitIn = 8'h00; tick(); tick();
    pivotRun();
    checkOut("R3 idle timer expiry", 1'b1, 2'd2, 2'd0, 16'h0100);
  endtask

  task automatic testZero();
    searchEn = 1'b0;
    wr(16'h0100, 2'd0);
    searchEn = 1'b1;
    pivotRun();
    checkOut("R7 zero weight no report", 1'b0, 2'd2, 2'd0, 16'h0100);
    tick();
    checkOut("R7 outputs held", 1'b0, 2'd2, 2'd0, 16'h0100);
  endtask

  task automatic testDisable();
    searchEn = 1'b0;
    wr(16'h0100, 2'd3);
    searchEn = 1'b1;
    hitIn = 8'h10; tick();
    hitIn = 8'h00; searchEn = 1'b0; tick();
    searchEn = 1'b1; tick(); tick(); tick();
    checkOut("R9 aborted window", 1'b0, 2'd2, 2'd0, 16'h0100);
    pivotRun();
    checkOut("R9 fresh window after re-enable", 1'b1, 2'd3, 2'd0, 16'h0100);
  endtask

  task automatic testWriteLock();
    searchEn = 1'b1;
    wr(16'h0100, 2'd0);
    tick();
    pivotRun();
    checkOut("R10 write ignored while searching", 1'b1, 2'd3, 2'd0, 16'h0100);
    searchEn = 1'b0;
    wr(16'h0100, 2'd1);
    searchEn = 1'b1;
    pivotRun();
    checkOut("R10 write taken while idle", 1'b1, 2'd1, 2'd0, 16'h0100);
  endtask

  task automatic testCloseEdge();
    searchEn = 1'b0;
    wr(16'h0102, 2'd3);
    searchEn = 1'b1;
    hitIn = 8'h10; tick();        // edge k
    hitIn = 8'h00; tick(); tick();
    hitIn = 8'h11; tick();        // closing edge k+3
    checkOut("R8 report at close", 1'b1, 2'd1, 2'd0, 16'h0100);
    hitIn = 8'h10; tick();        // edge k+4, new pivot
    hitIn = 8'h00;
    checkValid("R8 no strobe after close", 1'b0);
    tick();
    tick();                       // edge k+6
    checkValid("R8 closing-edge pivot discarded", 1'b0);
    tick();                       // edge k+7
    checkOut("R8 closing-edge hits discarded", 1'b1, 2'd1, 2'd0, 16'h0100);
  endtask

  initial begin
    rstN = 1'b0; searchEn = 1'b0; hitIn = 8'h00;
    tblWe = 1'b0; tblAddr = 16'h0000; tblData = 2'd0;
    tick(); tick();
    rstN = 1'b1;
    tick();
    testReset();
    testBest();
    testTie();
    testNeighbour();
    testExpire();
    testZero();
    testDisable();
    testWriteLock();
    testCloseEdge();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule